// File: doc/BRIEF.md
# Bidirectional Routing Repeater

This block sits between two routing segments and can pass signals across them in either direction. Each of its two sides has two connections: a short sector wire and a long global wire. That gives four connections in all. Each connection has its own 3-bit driver code. The code decides whether the repeater drives that connection. If it does, the code also picks which other connection supplies the value.

The block is purely combinational. Its inputs are the value currently present on each of the four connections and the four driver codes. For each connection it produces a drive value and a drive-enable; no tristate buffers are built. A connection's output is always taken from some other connection's input, never from its own, so no combinational loop can form through the repeater. A code with more than one bit set is illegal. For such a code the driver is turned off and an error flag is raised for that connection.

Top module: `routeRepeater`

## Requirements
- R1: Connections are indexed 0 = side A sector, 1 = side A global, 2 = side B sector, 3 = side B global. The code for connection c occupies `drvCode[3*c+2:3*c]`, and each connection's value occupies `wireIn`/`wireOut` bits `[WIDTH*c +: WIDTH]`.
- R2: Code 3'b000 gives `driveEn[c]`=0, `codeErr[c]`=0 and `wireOut` for c all zeros.
- R3: Code 3'b100 gives `driveEn[c]`=1, `codeErr[c]`=0, and `wireOut` for c equals the global wire input on the opposite side.
- R4: Code 3'b010 gives `driveEn[c]`=1, `codeErr[c]`=0, and `wireOut` for c equals the sector wire input on the opposite side.
- R5: Code 3'b001 gives `driveEn[c]`=1, `codeErr[c]`=0, and `wireOut` for c equals the input of the other wire on the same side. For example, side A sector is driven from side A global.
- R6: Codes 3'b011, 3'b101, 3'b110 and 3'b111 give `driveEn[c]`=0, `codeErr[c]`=1 and `wireOut` for c all zeros.
- R7: The outputs of a connection depend only on its own code. Changing another connection's code leaves them unchanged.
- R8: A connection's own input value never affects its own outputs, whatever its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wireIn | input | 4*WIDTH | Present value of each connection |
| drvCode | input | 12 | Three-bit driver code per connection |
| wireOut | output | 4*WIDTH | Value the repeater drives onto each connection |
| driveEn | output | 4 | Drive-enable per connection |
| codeErr | output | 4 | Illegal-code flag per connection |

## Verification
The checks assume that `wireIn` and `drvCode` are fully known. Each check is skipped while any bit of them is X or Z, because the outputs are not defined then. The bench drives every input bit to a definite 0 or 1 from time zero and changes inputs only on the falling clock edge. Each checked relation is therefore evaluated on settled, known values.

// File: rtl/rptr_pkg.sv
package rptr_pkg;
  localparam int NUM_SIDES = 2;
  localparam int WIRES_PER_SIDE = 2;
  localparam int NUM_CONN = NUM_SIDES * WIRES_PER_SIDE;
  localparam int CODE_W = 3;

  // Per-connection select strobes from control to datapath
  typedef struct packed {
    logic oppGlobal;
    logic oppSector;
    logic sameSide;
    logic illegal;
  } drvStrobe_t;

  // Index helpers: c = side*2 + kind, kind 0 = sector, 1 = global
  function automatic int oppGlobalIdx(input int c);
    return ((c / WIRES_PER_SIDE) ^ 1) * WIRES_PER_SIDE + 1;
  endfunction

  function automatic int oppSectorIdx(input int c);
    return ((c / WIRES_PER_SIDE) ^ 1) * WIRES_PER_SIDE;
  endfunction

  function automatic int sameOtherIdx(input int c);
    return (c / WIRES_PER_SIDE) * WIRES_PER_SIDE + ((c % WIRES_PER_SIDE) ^ 1);
  endfunction
endpackage

// File: rtl/rptr_ctrl.sv
module rptr_ctrl
  import rptr_pkg::*;
(
  input  logic [NUM_CONN*CODE_W-1:0]  drvCode,
  output drvStrobe_t [NUM_CONN-1:0]   strobes
);
  for (genvar c = 0; c < NUM_CONN; c++) begin : g_dec
    logic [CODE_W-1:0] code;
    assign code = drvCode[c*CODE_W +: CODE_W];
    always_comb begin
      strobes[c] = '0;
      unique case (code)
        3'b000: ;
        3'b100: strobes[c].oppGlobal = 1'b1;
        3'b010: strobes[c].oppSector = 1'b1;
        3'b001: strobes[c].sameSide  = 1'b1;
        default: strobes[c].illegal  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/rptr_dpath.sv
module rptr_dpath
  import rptr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [NUM_CONN*WIDTH-1:0] wireIn,
  input  drvStrobe_t [NUM_CONN-1:0] strobes,
  output logic [NUM_CONN*WIDTH-1:0] wireOut,
  output logic [NUM_CONN-1:0]       driveEn,
  output logic [NUM_CONN-1:0]       codeErr
);
  for (genvar c = 0; c < NUM_CONN; c++) begin : g_conn
    localparam int OG = oppGlobalIdx(c);
    localparam int OS = oppSectorIdx(c);
    localparam int SO = sameOtherIdx(c);
    logic [WIDTH-1:0] outVal;
    always_comb begin
      outVal = '0;
      if (strobes[c].oppGlobal) outVal = wireIn[OG*WIDTH +: WIDTH];
      if (strobes[c].oppSector) outVal = wireIn[OS*WIDTH +: WIDTH];
      if (strobes[c].sameSide)  outVal = wireIn[SO*WIDTH +: WIDTH];
    end
    assign wireOut[c*WIDTH +: WIDTH] = outVal;
    assign driveEn[c] = strobes[c].oppGlobal | strobes[c].oppSector | strobes[c].sameSide;
    assign codeErr[c] = strobes[c].illegal;
  end
endmodule

// File: rtl/routeRepeater.sv
module routeRepeater
  import rptr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [NUM_CONN*WIDTH-1:0]  wireIn,
  input  logic [NUM_CONN*CODE_W-1:0] drvCode,
  output logic [NUM_CONN*WIDTH-1:0]  wireOut,
  output logic [NUM_CONN-1:0]        driveEn,
  output logic [NUM_CONN-1:0]        codeErr
);
  drvStrobe_t [NUM_CONN-1:0] strobes;

  rptr_ctrl u_ctrl (
    .drvCode (drvCode),
    .strobes (strobes)
  );

  rptr_dpath #(.WIDTH(WIDTH)) u_dpath (
    .wireIn  (wireIn),
    .strobes (strobes),
    .wireOut (wireOut),
    .driveEn (driveEn),
    .codeErr (codeErr)
  );
endmodule

// File: rtl/routeRepeater_chk.sv
module routeRepeater_chk
  import rptr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic [NUM_CONN*WIDTH-1:0]  wireIn,
  input logic [NUM_CONN*CODE_W-1:0] drvCode,
  input logic [NUM_CONN*WIDTH-1:0]  wireOut,
  input logic [NUM_CONN-1:0]        driveEn,
  input logic [NUM_CONN-1:0]        codeErr
);
  always_comb begin
    if (!$isunknown({wireIn, drvCode})) begin
      for (int c = 0; c < NUM_CONN; c++) begin
        logic [CODE_W-1:0] cd;
        logic [WIDTH-1:0]  ov;
        cd = drvCode[c*CODE_W +: CODE_W];
        ov = wireOut[c*WIDTH +: WIDTH];
        if (cd == 3'b000)
          a_r2_disabled: assert (!driveEn[c] && !codeErr[c] && ov == '0);
        if (cd == 3'b100)
          a_r3_opp_global: assert (driveEn[c] && ov == wireIn[oppGlobalIdx(c)*WIDTH +: WIDTH]);
        if (cd == 3'b010)
          a_r4_opp_sector: assert (driveEn[c] && ov == wireIn[oppSectorIdx(c)*WIDTH +: WIDTH]);
        if (cd == 3'b001)
          a_r5_same_side: assert (driveEn[c] && ov == wireIn[sameOtherIdx(c)*WIDTH +: WIDTH]);
        if ($countones(cd) > 1)
          a_r6_illegal: assert (codeErr[c] && !driveEn[c] && ov == '0);
        a_r6_err_excl: assert (!(codeErr[c] && driveEn[c]));
      end
    end
  end
endmodule

bind routeRepeater routeRepeater_chk #(.WIDTH(WIDTH)) u_chk (
  .wireIn  (wireIn),
  .drvCode (drvCode),
  .wireOut (wireOut),
  .driveEn (driveEn),
  .codeErr (codeErr)
);

// File: tb/test_routeRepeater.sv
`timescale 1ns/1ps
module test_routeRepeater;
  localparam int W = 4;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [N*W-1:0] wireIn = '0;
  logic [N*3-1:0] drvCode = '0;
  logic [N*W-1:0] wireOut;
  logic [N-1:0]   driveEn;
  logic [N-1:0]   codeErr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  routeRepeater #(.WIDTH(W)) i_routeRepeater (
    .wireIn(wireIn), .drvCode(drvCode), .wireOut(wireOut),
    .driveEn(driveEn), .codeErr(codeErr)
  );

  // Index relations taken from R1: 0 A-sector, 1 A-global, 2 B-sector, 3 B-global
  function automatic int oppG(int c); return (c < 2) ? 3 : 1; endfunction
  function automatic int oppS(int c); return (c < 2) ? 2 : 0; endfunction
  function automatic int sameO(int c);
    case (c) 0: return 1; 1: return 0; 2: return 3; default: return 2; endcase
  endfunction

  function automatic logic [W-1:0] inOf(int c); return wireIn[c*W +: W]; endfunction

  task automatic apply(input logic [N*3-1:0] codes, input logic [N*W-1:0] vals);
    @(negedge clk);
    drvCode = codes;
    wireIn = vals;
    #1;
  endtask

  task automatic checkConn(input string req, input int c,
                           input logic [W-1:0] expOut, input logic expEn, input logic expErr);
    checks++;
    if (wireOut[c*W +: W] !== expOut || driveEn[c] !== expEn || codeErr[c] !== expErr) begin
      failures++;
      $display("FAIL %s conn%0d: out=%h en=%b err=%b expected out=%h en=%b err=%b",
               req, c, wireOut[c*W +: W], driveEn[c], codeErr[c], expOut, expEn, expErr);
    end
  endtask

  // R2: all codes zero after start
  task automatic t_idle();
    apply('0, 16'hA5C3);
    for (int c = 0; c < N; c++) checkConn("R2", c, '0, 1'b0, 1'b0);
  endtask

  // R3 and R1: every connection from the opposite global wire
  task automatic t_oppGlobal();
    apply({4{3'b100}}, 16'h4321);
    for (int c = 0; c < N; c++) checkConn("R3", c, inOf(oppG(c)), 1'b1, 1'b0);
    apply({4{3'b100}}, 16'h9E7B);
    for (int c = 0; c < N; c++) checkConn("R3", c, inOf(oppG(c)), 1'b1, 1'b0);
  endtask

  // R4
  task automatic t_oppSector();
    apply({4{3'b010}}, 16'h8D2F);
    for (int c = 0; c < N; c++) checkConn("R4", c, inOf(oppS(c)), 1'b1, 1'b0);
  endtask

  // R5
  task automatic t_sameSide();
    apply({4{3'b001}}, 16'h1B6E);
    for (int c = 0; c < N; c++) checkConn("R5", c, inOf(sameO(c)), 1'b1, 1'b0);
  endtask

  // R6: each illegal pattern on every connection
  task automatic t_illegal();
    logic [2:0] bad [4] = '{3'b011, 3'b101, 3'b110, 3'b111};
    for (int i = 0; i < 4; i++) begin
      apply({4{bad[i]}}, 16'hFFFF);
      for (int c = 0; c < N; c++) checkConn("R6", c, '0, 1'b0, 1'b1);
    end
  endtask

  // R1: mixed codes, each field in its own position
  task automatic t_mixed();
    // conn3=001, conn2=100, conn1=010, conn0=000
    apply({3'b001, 3'b100, 3'b010, 3'b000}, 16'hC9A6);
    checkConn("R1", 0, '0, 1'b0, 1'b0);
    checkConn("R1", 1, inOf(2), 1'b1, 1'b0);
    checkConn("R1", 2, inOf(1), 1'b1, 1'b0);
    checkConn("R1", 3, inOf(2), 1'b1, 1'b0);
  endtask

  // R7: changing connection 2's code leaves others unchanged
  task automatic t_independent();
    logic [N*3-1:0] base = {3'b010, 3'b000, 3'b100, 3'b001};
    logic [2:0] alt [5] = '{3'b000, 3'b100, 3'b010, 3'b001, 3'b111};
    for (int i = 0; i < 5; i++) begin
      logic [N*3-1:0] cd = base;
      cd[8:6] = alt[i];
      apply(cd, 16'h7E18);
      checkConn("R7", 0, inOf(1), 1'b1, 1'b0);
      checkConn("R7", 1, inOf(3), 1'b1, 1'b0);
      checkConn("R7", 3, inOf(0), 1'b1, 1'b0);
    end
  endtask

  // R8: own input varies, own output does not
  task automatic t_selfInput();
    logic [2:0] cs [4] = '{3'b100, 3'b010, 3'b001, 3'b000};
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < N; c++) begin
        logic [N*W-1:0] v = 16'h5A3C;
        logic [W-1:0] first;
        apply({4{cs[k]}}, v);
        first = wireOut[c*W +: W];
        v[c*W +: W] = ~v[c*W +: W];
        apply({4{cs[k]}}, v);
        checkConn("R8", c, first, (cs[k] != 3'b000), 1'b0);
      end
    end
  endtask

  initial begin
    #20 rst_n = 1'b1;
    t_idle();
    t_oppGlobal();
    t_oppSector();
    t_sameSide();
    t_illegal();
    t_mixed();
    t_independent();
    t_selfInput();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule